// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block sits in front of a burst-capable memory. It takes a full word address at the start of an access and hands out the address of each beat in a four-beat burst. The address is captured when either of two active-low load strobes is low at a rising clock edge. The upper bits are held for the whole burst. The low two bits start from the captured value and move along one of two fixed orders. The `mode_ilv` input is meant to be held static and picks the order:

- **Linear order:** the start value plus a beat count, modulo four.
- **Interleaved order:** the start value XOR the beat count.

The beat count steps on each rising edge while the active-low advance input is low. It stays put while that input is high. Because only the low bits take part, the burst always stays inside its aligned group of four words and returns to the start word after four steps.

Control is a two-state machine:

- **`ST_IDLE`** is entered by reset. No burst is loaded, and the advance input is ignored.
- **`ST_ACTIVE`** is entered from `ST_IDLE` on a load strobe (transition *load*).

Inside `ST_ACTIVE` there are three self-transitions:

- *reload*: a strobe captures a new address and restarts the beat count. It wins over advance.
- *advance*: no strobe, and advance is low.
- *hold*: no strobe, and advance is high.

The only way back to `ST_IDLE` is the synchronous reset.

Top module: `bseq_burst_addr`

## Requirements
- R1: While `rst` is high at a rising edge, the captured address and beat count are cleared, so `addr_out` reads all zeros after that edge.
- R2: When `strobe_a_n` or `strobe_b_n` (either one, or both) is low at a rising edge, `addr_in` is captured, and `addr_out` equals that value after the edge.
- R3: With `mode_ilv` = 0, after k advancing edges since the last load, the low two bits of `addr_out` are (start + k) mod 4.
- R4: With `mode_ilv` = 1, after k advancing edges since the last load, the low two bits of `addr_out` are start XOR (k mod 4).
- R5: An edge with both strobes high and `adv_n` high leaves `addr_out` unchanged.
- R6: Bits `ADDR_W-1` down to 2 of `addr_out` equal the captured address for the whole burst, whatever advance does.
- R7: After the fourth advancing edge, `addr_out` is back at the captured start address, and the sequence then repeats.
- R8: A strobe at an edge where `adv_n` is also low loads `addr_in` and restarts the beat count at zero, and the advance is dropped.
- R9: After reset and before any load, edges with `adv_n` low leave `addr_out` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_a_n | input | 1 | First address load strobe, active low |
| strobe_b_n | input | 1 | Second address load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_in | input | ADDR_W | External word address |
| addr_out | output | ADDR_W | Current beat word address |

## Verification
Every result is due at the first rising edge after its stimulus. Load, advance, hold and reset each act on the registers at that edge, and `addr_out` is a combinational map of those registers. The bench applies each stimulus at a falling edge, waits for the next rising edge, and samples one nanosecond later. At that point it compares against a model that it has advanced by exactly one edge. The sweep covers both orders, all four start words, both strobes and three upper-bit patterns. Each burst includes a hold, a full wrap and a load that collides with advance.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } bseq_state_e;

endpackage

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] beat
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            beat <= '0;
        end else if (step) begin
            beat <= beat + 1'b1;
        end
    end

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map #(
    parameter int CNT_W = 2
) (
    input  logic             ilv,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] low
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] xor_low;

    always_comb begin
        lin_low = start + beat;
        xor_low = start ^ beat;
        low     = ilv ? xor_low : lin_low;
    end

endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr #(
    parameter int ADDR_W    = 17,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              adv_n,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    import bseq_pkg::*;

    localparam int CNT_W = $clog2(BURST_LEN);
    localparam int HI_W  = ADDR_W - CNT_W;

    bseq_state_e      state_q;
    bseq_state_e      state_d;
    logic             load;
    logic             step;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0] beat_q;
    logic [CNT_W-1:0] low_bits;

    assign load = !strobe_a_n || !strobe_b_n;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = ST_ACTIVE;   // load
            ST_ACTIVE: state_d = ST_ACTIVE;             // reload / advance / hold
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // per-state controls
    always_comb begin
        step = 1'b0;
        unique case (state_q)
            ST_IDLE:   step = 1'b0;
            ST_ACTIVE: step = !load && !adv_n;
            default:   step = 1'b0;
        endcase
    end

    bseq_base_reg #(.ADDR_W(ADDR_W)) base_i (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (addr_in),
        .q    (base_q)
    );

    bseq_beat_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .step  (step),
        .beat  (beat_q)
    );

    bseq_order_map #(.CNT_W(CNT_W)) map_i (
        .ilv   (mode_ilv),
        .start (base_q[CNT_W-1:0]),
        .beat  (beat_q),
        .low   (low_bits)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign addr_out = {base_q[ADDR_W-1:CNT_W], low_bits};
        end else begin : g_lo
            assign addr_out = low_bits[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/bseq_burst_addr_chk.sv
module bseq_burst_addr_chk #(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  strobe_a_n,
    input logic                  strobe_b_n,
    input logic                  adv_n,
    input logic                  mode_ilv,
    input logic [ADDR_W-1:0]     addr_in,
    input logic [ADDR_W-1:0]     addr_out,
    input bseq_pkg::bseq_state_e state_q,
    input logic [CNT_W-1:0]      beat_q
);
    import bseq_pkg::*;

    logic             ld;
    logic [CNT_W-1:0] low_now;

    assign ld      = !strobe_a_n || !strobe_b_n;
    assign low_now = addr_out[CNT_W-1:0];

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0));

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (addr_out == $past(addr_in)));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && !ld && !adv_n && !mode_ilv)
        |=> (mode_ilv || CNT_W'(low_now - $past(low_now)) == CNT_W'(1)));

    assert_beat_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && !ld && !adv_n)
        |=> (beat_q == CNT_W'($past(beat_q) + 1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv_n) |=> ($stable(addr_out) || !$stable(mode_ilv)));

    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

    assert_idle_no_adv_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !ld) |=> (addr_out == '0));

endmodule

bind bseq_burst_addr bseq_burst_addr_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .strobe_a_n (strobe_a_n),
    .strobe_b_n (strobe_b_n),
    .adv_n      (adv_n),
    .mode_ilv   (mode_ilv),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .state_q    (state_q),
    .beat_q     (beat_q)
);

// File: tb/bseq_burst_addr_tb_top.sv
`timescale 1ns/1ps
module bseq_burst_addr_tb_top;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_a_n = 1'b1;
    logic          strobe_b_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          mode_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    logic [AW-1:0] m_base = '0;
    int            m_k    = 0;
    bit            m_act  = 0;

    always #2 clk = ~clk;

    bseq_burst_addr #(.ADDR_W(AW), .BURST_LEN(4)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .strobe_a_n (strobe_a_n),
        .strobe_b_n (strobe_b_n),
        .adv_n      (adv_n),
        .mode_ilv   (mode_ilv),
        .addr_in    (addr_in),
        .addr_out   (addr_out)
    );

    function automatic logic [AW-1:0] expect_addr(input bit ilv);
        int s;
        int lo;
        s  = int'(m_base[1:0]);
        lo = ilv ? (s ^ (m_k % 4)) : ((s + m_k) % 4);
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic check(input logic [AW-1:0] exp_v, input string tag);
        total++;
        if (addr_out !== exp_v) begin
            bad++;
            $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp_v);
        end
    endtask

    // one edge: drive at falling edge, sample 1 ns after rising edge
    task automatic cyc(input logic sa, input logic sb, input logic av,
                       input logic ilv, input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        strobe_a_n = sa;
        strobe_b_n = sb;
        adv_n      = av;
        mode_ilv   = ilv;
        addr_in    = a;
        @(posedge clk);
        if (!sa || !sb) begin
            m_base = a;
            m_k    = 0;
            m_act  = 1;
        end else if (m_act && !av) begin
            m_k = (m_k + 1) % 4;
        end
        #1;
        check(expect_addr(ilv), tag);
    endtask

    initial begin
        logic [AW-2:0] hi_pat [3];
        hi_pat[0] = '0;
        hi_pat[1] = '1;
        hi_pat[2] = 16'h5A3C;

        // R1: reset clears
        rst = 1'b1;
        addr_in = '1;
        repeat (3) @(posedge clk);
        #1;
        check('0, "R1 reset");
        @(negedge clk);
        rst = 1'b0;

        // R9: advance before any load has no effect
        cyc(1, 1, 0, 0, '1, "R9 idle advance");
        cyc(1, 1, 0, 1, '1, "R9 idle advance ilv");

        for (int m = 0; m < 2; m++) begin
            for (int u = 0; u < 3; u++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [AW-1:0] a;
                        logic [AW-1:0] a2;
                        string ord;
                        ord = (m == 1) ? "R4" : "R3";
                        a   = {hi_pat[u][AW-3:0], 2'(s)};
                        a2  = {~hi_pat[u][AW-3:0], 2'(3 - s)};
                        // R2: load via one strobe
                        cyc(w == 0 ? 1'b0 : 1'b1, w == 1 ? 1'b0 : 1'b1, 1, m[0], a, "R2 load");
                        cyc(1, 1, 0, m[0], ~a, {ord, " R6 step1"});
                        cyc(1, 1, 0, m[0], ~a, {ord, " R6 step2"});
                        cyc(1, 1, 1, m[0], ~a, "R5 hold");
                        cyc(1, 1, 0, m[0], ~a, {ord, " step3"});
                        cyc(1, 1, 0, m[0], ~a, "R7 wrap to start");
                        cyc(1, 1, 0, m[0], ~a, {ord, " R7 after wrap"});
                        // R8: strobe wins over advance
                        cyc(w == 1 ? 1'b0 : 1'b1, w == 0 ? 1'b0 : 1'b1, 0, m[0], a2, "R8 reload");
                        cyc(1, 1, 0, m[0], a, {ord, " R8 restart step"});
                        cyc(0, 0, 1, m[0], a, "R2 both strobes");
                    end
                end
            end
        end

        // R1: reset mid-burst
        cyc(1, 1, 0, 0, '0, "R3 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        m_base = '0; m_k = 0; m_act = 0;
        #1;
        check('0, "R1 reset mid-burst");
        @(negedge clk);
        rst = 1'b0;
        cyc(1, 1, 0, 0, '1, "R9 advance after reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule